// File: doc/BRIEF.md
# Time-Scheduled Transmit Buffer Arbiter

This block sits between a set of transmit frame buffers (two by default) and a bus protocol engine. Each buffer presents a loaded flag, a 64-bit scheduled transmit time and a frame identifier. The block compares every loaded buffer's schedule against a free-running 64-bit timestamp that advances once per clock. A buffer may be offered only once the timestamp has reached its schedule. When more than one buffer is due, the lowest buffer index wins. The schedules of the competing buffers are never compared with each other.

The offer to the protocol engine is a valid/ready stream. `tx_valid` says a due frame is on offer, and `tx_sel`/`tx_id` name it. The engine raises `tx_ready` for one cycle at each bit boundary while the bus is idle. A transfer (`tx_start`) happens in a cycle where both are high. Back-pressure is simply `tx_ready` staying low: the offer remains up and nothing is consumed. Before it is accepted, the offer may move to a lower-indexed buffer that has just become due.

After a transfer the selection stays locked (`tx_active`) until the engine reports `tx_done` or `tx_lost`. Only then does a new round begin. The taken buffer reads as empty. A lost transfer puts that frame back into contention.

Top module: `tta_arbiter`

## Requirements
- R1: While reset is asserted and at release, `tx_valid`, `tx_start` and `tx_active` are 0, `tx_sel` is 0, and every `buf_empty` bit is 1 when no buffer is loaded.
- R2: No buffer is offered while `ts_now` is below its scheduled time. The comparison is unsigned over all 64 bits, including when the upper 32 bits of the two values differ.
- R3: `tx_valid` rises exactly one cycle after the first clock edge at which `ts_now` is greater than or equal to the schedule of a loaded buffer that has not been taken.
- R4: A buffer loaded with a schedule that is already in the past is offered in the cycle after it is loaded.
- R5: `tx_start` is high exactly in the cycles where `tx_valid` and `tx_ready` are both high, and never for two cycles in a row. While `tx_ready` stays low, a due offer stays up and no start occurs.
- R6: Among due buffers the lowest index wins, whatever their schedules. `tx_sel` gives the winner's index and `tx_id` gives its identifier.
- R7: `buf_empty[i]` is 0 while `buf_valid[i]` is 1 and its frame has not been taken. It becomes 1 in the cycle after buffer i is started. Deasserting `buf_valid[i]` clears the taken mark.
- R8: From the cycle after a start, `tx_active` is 1. While it is 1, `tx_valid` is 0 and `tx_sel` holds. `tx_done` ends the lock, so `tx_active` is 0 in the next cycle.
- R9: `tx_lost` ends the lock and returns the locked buffer to pending: its `buf_empty` is 0 in the next cycle and it is offered again.
- R10: `tx_ready` has no effect when no buffer is due. No start occurs and no state changes.
- R11: With `tx_ready` pulsing once every 130 cycles and the engine otherwise idle, a start follows the scheduled time by at least 1 and at most 150 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_now | input | TS_W | Free-running timestamp, +1 per clock |
| buf_valid | input | NBUF | Buffer i holds a loaded frame |
| buf_time | input | NBUF*TS_W | Scheduled time of buffer i in slice i |
| buf_id | input | NBUF*ID_W | Identifier of buffer i in slice i |
| tx_ready | input | 1 | Engine accepts a frame this cycle (idle bus, bit boundary) |
| tx_done | input | 1 | Locked transfer completed |
| tx_lost | input | 1 | Locked transfer failed, frame returns to pending |
| tx_valid | output | 1 | A due frame is on offer |
| tx_start | output | 1 | Transfer pulse (valid and ready) |
| tx_sel | output | IDX_W | Index of offered or locked buffer |
| tx_id | output | ID_W | Identifier of the buffer named by tx_sel |
| tx_active | output | 1 | Selection locked, transmission in progress |
| buf_empty | output | NBUF | Buffer i holds no pending frame |

## Verification
The due flag is registered, so `tx_valid` follows the timestamp crossing by one cycle. `tx_start` is combinational with `tx_ready` in the same cycle. `tx_active` and `buf_empty` react one cycle after the start, and a lost frame is offered again two cycles after `tx_lost`. The bench drives every input 1 ns after the falling edge and samples all outputs 5 ns after it. A behavioural model updated on each rising edge supplies the expected value for every output in every cycle. Directed scenarios count cycles from the load to pin the exact rise of `tx_valid` and to bound the start delay.

// File: rtl/tta_pkg.sv
package tta_pkg;
  typedef enum logic {
    ARB_OPEN   = 1'b0,
    ARB_LOCKED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/tta_due.sv
module tta_due #(
  parameter int NBUF = 2,
  parameter int TS_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      ts_now,
  input  logic [NBUF-1:0]      buf_valid,
  input  logic [NBUF*TS_W-1:0] buf_time,
  input  logic [NBUF-1:0]      grant_hot,
  input  logic [NBUF-1:0]      requeue_hot,
  output logic [NBUF-1:0]      due,
  output logic [NBUF-1:0]      buf_empty
);

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    logic            taken_q;
    logic            due_q;
    logic [TS_W-1:0] sched;

    assign sched = buf_time[i*TS_W +: TS_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        taken_q <= 1'b0;
        due_q   <= 1'b0;
      end else begin
        due_q <= buf_valid[i] & ~taken_q & (ts_now >= sched);
        if (!buf_valid[i] || requeue_hot[i]) taken_q <= 1'b0;
        else if (grant_hot[i])               taken_q <= 1'b1;
      end
    end

    assign due[i]       = due_q;
    assign buf_empty[i] = ~buf_valid[i] | taken_q;
  end

endmodule

// File: rtl/tta_pick.sv
module tta_pick #(
  parameter int NBUF  = 2,
  parameter int IDX_W = 1
) (
  input  logic [NBUF-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tta_arbiter.sv
module tta_arbiter
  import tta_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int TS_W  = 64,
  parameter int ID_W  = 29,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      ts_now,
  input  logic [NBUF-1:0]      buf_valid,
  input  logic [NBUF*TS_W-1:0] buf_time,
  input  logic [NBUF*ID_W-1:0] buf_id,
  input  logic                 tx_ready,
  input  logic                 tx_done,
  input  logic                 tx_lost,
  output logic                 tx_valid,
  output logic                 tx_start,
  output logic [IDX_W-1:0]     tx_sel,
  output logic [ID_W-1:0]      tx_id,
  output logic                 tx_active,
  output logic [NBUF-1:0]      buf_empty
);

  arb_state_e       state_q;
  logic [IDX_W-1:0] lock_idx_q;
  logic [NBUF-1:0]  due;
  logic [NBUF-1:0]  grant_hot;
  logic [NBUF-1:0]  requeue_hot;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  tta_due #(.NBUF(NBUF), .TS_W(TS_W)) u_due (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_now      (ts_now),
    .buf_valid   (buf_valid),
    .buf_time    (buf_time),
    .grant_hot   (grant_hot),
    .requeue_hot (requeue_hot),
    .due         (due),
    .buf_empty   (buf_empty)
  );

  tta_pick #(.NBUF(NBUF), .IDX_W(IDX_W)) u_pick (
    .req (due),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign tx_active = (state_q == ARB_LOCKED);
  assign tx_valid  = (state_q == ARB_OPEN) && pick_any;
  assign tx_start  = tx_valid && tx_ready;
  assign tx_sel    = tx_active ? lock_idx_q : pick_idx;
  assign tx_id     = buf_id[tx_sel*ID_W +: ID_W];

  always_comb begin
    grant_hot   = '0;
    requeue_hot = '0;
    if (tx_start)             grant_hot[pick_idx]     = 1'b1;
    if (tx_active && tx_lost) requeue_hot[lock_idx_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ARB_OPEN;
      lock_idx_q <= '0;
    end else begin
      case (state_q)
        ARB_OPEN: if (tx_start) begin
          state_q    <= ARB_LOCKED;
          lock_idx_q <= pick_idx;
        end
        ARB_LOCKED: if (tx_done || tx_lost) state_q <= ARB_OPEN;
        default: state_q <= ARB_OPEN;
      endcase
    end
  end

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R5
  AST_START_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_active); // R8
  AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> buf_empty[$past(tx_sel)]); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_done && !tx_lost) |=> $stable(tx_sel) && !tx_valid); // R8
  AST_LOST_REQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_lost && buf_valid[tx_sel]) |=> !buf_empty[$past(tx_sel)]); // R9

endmodule

// File: tb/tta_arbiter_tb.sv
module tta_arbiter_tb;
  localparam int BIT_CYC   = 130;
  localparam int FRAME_CYC = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ts_now = 64'h0000_0001_FFFF_FFF0;
  logic [1:0]  buf_valid = 2'b00;
  logic [63:0] btime [2];
  logic [28:0] bid [2];
  logic        tx_ready = 1'b0, tx_done = 1'b0, tx_lost = 1'b0;
  logic        tx_valid, tx_start, tx_active;
  logic [0:0]  tx_sel;
  logic [28:0] tx_id;
  logic [1:0]  buf_empty;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tta_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .buf_valid(buf_valid),
    .buf_time({btime[1], btime[0]}), .buf_id({bid[1], bid[0]}),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_lost(tx_lost),
    .tx_valid(tx_valid), .tx_start(tx_start), .tx_sel(tx_sel), .tx_id(tx_id),
    .tx_active(tx_active), .buf_empty(buf_empty)
  );

  always @(negedge clk) ts_now <= ts_now + 64'd1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // engine stand-in: ready once per bit when idle, done/lost after a frame
  bit eng_en = 1'b0, eng_busy = 1'b0, lose_mode = 1'b0, started_q = 1'b0;
  int phase = 0, eng_cnt = 0;

  always @(posedge clk) started_q = tx_start;

  always begin
    @(negedge clk); #1;
    tx_done = 1'b0;
    tx_lost = 1'b0;
    if (!rst_n) begin
      phase = 0; eng_busy = 1'b0; tx_ready = 1'b0;
    end else begin
      if (eng_busy) begin
        if (eng_cnt == 0) begin
          eng_busy = 1'b0;
          if (lose_mode) tx_lost = 1'b1; else tx_done = 1'b1;
        end else eng_cnt--;
      end else if (started_q) begin
        eng_busy = 1'b1; eng_cnt = FRAME_CYC;
      end
      phase = (phase == BIT_CYC - 1) ? 0 : phase + 1;
      tx_ready = eng_en && !eng_busy && (phase == BIT_CYC - 1);
    end
  end

  // behavioural reference, advanced on each rising edge
  bit [1:0] m_due = 2'b00, m_taken = 2'b00;
  bit       m_busy = 1'b0;
  int       m_lock = 0;

  always @(posedge clk) begin
    bit [1:0] nt;
    bit       st;
    int       pk;
    if (!rst_n) begin
      m_due = 2'b00; m_taken = 2'b00; m_busy = 1'b0; m_lock = 0;
    end else begin
      st = !m_busy && (m_due != 2'b00) && tx_ready;
      pk = m_due[0] ? 0 : 1;
      nt = m_taken;
      if (m_busy && (tx_done || tx_lost)) begin
        if (tx_lost) nt[m_lock] = 1'b0;
        m_busy = 1'b0;
      end else if (st) begin
        nt[pk] = 1'b1; m_busy = 1'b1; m_lock = pk;
      end
      for (int i = 0; i < 2; i++) begin
        if (!buf_valid[i]) nt[i] = 1'b0;
        m_due[i] = buf_valid[i] && !m_taken[i] && (ts_now >= btime[i]);
      end
      m_taken = nt;
    end
  end

  always begin
    bit       e_valid, e_start;
    int       e_sel;
    bit [1:0] e_empty;
    @(negedge clk); #5;
    if (rst_n && !finished) begin
      e_valid = !m_busy && (m_due != 2'b00);
      e_start = e_valid && tx_ready;
      e_sel   = m_busy ? m_lock : (m_due[0] ? 0 : (m_due[1] ? 1 : 0));
      e_empty = ~buf_valid | m_taken;
      chk(tx_valid === e_valid, "R3", "tx_valid model", 64'(tx_valid), 64'(e_valid));
      chk(tx_start === e_start, "R5", "tx_start model", 64'(tx_start), 64'(e_start));
      chk(tx_sel === 1'(e_sel), "R6", "tx_sel model", 64'(tx_sel), 64'(e_sel));
      chk(tx_id === bid[e_sel], "R6", "tx_id model", 64'(tx_id), 64'(bid[e_sel]));
      chk(tx_active === m_busy, "R8", "tx_active model", 64'(tx_active), 64'(m_busy));
      chk(buf_empty === e_empty, "R7", "buf_empty model", 64'(buf_empty), 64'(e_empty));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=%0d expected<=%0d", cyc, 60000);
      summary();
    end
  end

  task automatic nxt();
    @(negedge clk); #5;
  endtask

  task automatic wait_start();
    while (!tx_start) nxt();
  endtask

  task automatic wait_done();
    while (!tx_done) nxt();
  endtask

  task automatic drop_all();
    @(negedge clk); #1;
    buf_valid = 2'b00;
  endtask

  initial begin
    logic [63:0] t_sched, dly;
    int n_st;
    btime[0] = '0; btime[1] = '0;
    bid[0] = 29'h0ABC_DEF; bid[1] = 29'h1234_567;

    // R1: reset state
    repeat (3) nxt();
    chk(!tx_valid && !tx_start && !tx_active, "R1", "flags in reset",
        {61'd0, tx_valid, tx_start, tx_active}, 64'd0);
    chk(tx_sel == 1'b0, "R1", "tx_sel in reset", 64'(tx_sel), 64'd0);
    chk(buf_empty == 2'b11, "R1", "buf_empty in reset", 64'(buf_empty), 64'd3);
    @(negedge clk); #1;
    rst_n = 1'b1;
    eng_en = 1'b1;
    nxt();
    chk(!tx_valid && !tx_active && tx_sel == 1'b0, "R1", "state after release",
        {62'd0, tx_valid, tx_active}, 64'd0);

    // R2/R3/R11: buffer 0, schedule crossing the 32-bit carry
    @(negedge clk); #1;
    t_sched = ts_now + 64'd40;
    btime[0] = t_sched;
    buf_valid[0] = 1'b1;
    for (int n = 1; n <= 41; n++) begin
      nxt();
      if (n <= 40) chk(!tx_valid, "R2", "offer before schedule", 64'(tx_valid), 64'd0);
      else         chk(tx_valid, "R3", "offer one cycle after due", 64'(tx_valid), 64'd1);
    end
    wait_start();
    dly = ts_now - t_sched;
    chk(dly >= 64'd1 && dly <= 64'd150, "R11", "start delay buf0", dly, 64'd150);
    chk(tx_sel == 1'b0, "R6", "winner buf0", 64'(tx_sel), 64'd0);
    wait_done();
    nxt();
    chk(!tx_active, "R8", "unlock after done", 64'(tx_active), 64'd0);
    drop_all();

    // R7/R11: buffer 1 alone
    @(negedge clk); #1;
    t_sched = ts_now + 64'd777;
    btime[1] = t_sched;
    buf_valid[1] = 1'b1;
    nxt();
    chk(buf_empty[1] == 1'b0, "R7", "loaded buf1 pending", 64'(buf_empty[1]), 64'd0);
    wait_start();
    dly = ts_now - t_sched;
    chk(dly >= 64'd1 && dly <= 64'd150, "R11", "start delay buf1", dly, 64'd150);
    chk(tx_sel == 1'b1, "R6", "winner buf1", 64'(tx_sel), 64'd1);
    wait_done();
    drop_all();

    // R4/R5/R6/R7/R8: both past, buf1 has the earlier schedule
    @(negedge clk); #1;
    eng_en = 1'b0;
    btime[1] = ts_now - 64'd100;
    btime[0] = ts_now - 64'd5;
    buf_valid = 2'b11;
    nxt();
    chk(tx_valid, "R4", "past schedule offered", 64'(tx_valid), 64'd1);
    chk(tx_sel == 1'b0, "R6", "lowest index wins", 64'(tx_sel), 64'd0);
    chk(tx_id == bid[0], "R6", "winner identifier", 64'(tx_id), 64'(bid[0]));
    for (int k = 0; k < 10; k++) begin
      nxt();
      chk(tx_valid && !tx_start, "R5", "offer held without ready",
          {62'd0, tx_valid, tx_start}, 64'd2);
    end
    @(negedge clk); #1;
    eng_en = 1'b1;
    nxt();
    wait_start();
    chk(tx_sel == 1'b0, "R6", "started buf0 first", 64'(tx_sel), 64'd0);
    nxt();
    chk(tx_active && !tx_valid, "R8", "locked, no offer",
        {62'd0, tx_active, tx_valid}, 64'd2);
    chk(buf_empty == 2'b01, "R7", "taken buf0 empty, buf1 pending", 64'(buf_empty), 64'd1);
    wait_done();
    nxt();
    chk(!tx_active, "R8", "unlock after done", 64'(tx_active), 64'd0);
    wait_start();
    chk(tx_sel == 1'b1, "R6", "buf1 next", 64'(tx_sel), 64'd1);
    wait_done();
    drop_all();

    // R9: lost frame returns
    @(negedge clk); #1;
    lose_mode = 1'b1;
    btime[0] = ts_now - 64'd1;
    buf_valid[0] = 1'b1;
    nxt();
    while (!tx_lost) nxt();
    lose_mode = 1'b0;
    nxt();
    chk(buf_empty[0] == 1'b0 && !tx_active, "R9", "requeued after lost",
        {62'd0, buf_empty[0], tx_active}, 64'd0);
    wait_start();
    chk(tx_sel == 1'b0, "R9", "re-offered buf0", 64'(tx_sel), 64'd0);
    wait_done();
    drop_all();

    // R10: ready with nothing due
    n_st = 0;
    for (int k = 0; k < 300; k++) begin
      nxt();
      if (tx_start) n_st++;
    end
    chk(n_st == 0, "R10", "starts with nothing due", 64'(n_st), 64'd0);

    summary();
  end
endmodule